// File: doc/BRIEF.md
# Serial Wire Debug Host Engine

This block is the host end of a two-wire serial debug link. It generates the serial clock. It owns the direction of the shared data line, and it runs whole link operations from a single command. There are three kinds of command. A register transfer sends a request, reads the target's acknowledge, then moves one 32-bit data word to or from a debug-port or access-port register. A line reset holds the data line high for a fixed number of clocks. The protocol switch sequence wraps the 16-bit select pattern between two line resets.

The engine splits each serial bit into a low half and a high half. Each half lasts `HALF_DIV` system clocks. The host changes the data line only at the start of a bit, when the serial clock falls. It samples the target at the rising edge. The host hands the line over at every change of driver and inserts one released turnaround bit there. It always clocks a read's full data and parity phase, so the link stays aligned. The result is reported with a one-cycle `done` pulse: the acknowledge, the read data and a parity-error flag.

Top module: `swd_host`

## Requirements
- R1: A transfer starts with 8 host-driven bits, sent least-significant bit first. In send order they are 1, `cmd_ap`, `cmd_rnw`, `cmd_addr[0]`, `cmd_addr[1]`, the even parity of those four bits, 0, 1.
- R2: In the bit right after the request, the host releases the line (`swdio_oe`=0). The line stays released for the next 3 bits, which carry the acknowledge.
- R3: The acknowledge is taken bit 0 first and reported on `ack`. The value 3'b001 means OK, 3'b010 means WAIT and 3'b100 means FAULT.
- R4: After an OK acknowledge on a read, the host samples 33 released bits: 32 data bits LSB first, then a parity bit. It adds one more released bit and presents the data on `rdata`, so the transfer is 46 bits long. `rdata` holds its value after any other command.
- R5: `parity_error` is 1 after a read when the XOR of the 32 data bits differs from the received parity bit. It is 0 after any other transfer.
- R6: After an OK acknowledge on a write, the host releases the line for one bit. It then drives `cmd_wdata` LSB first, followed by its even parity, so the transfer is 46 bits long.
- R7: Any acknowledge other than OK skips the data phase. WAIT, FAULT, 3'b111 from an undriven line and every other value all behave this way. One released bit follows and the transfer ends after 13 bits, with the host driving the line again.
- R8: A line-reset command (`cmd_op`=2'b01) clocks exactly `RESET_CYCLES` bits with the line driven high.
- R9: A switch command (`cmd_op`=2'b10 or 2'b11) sends a line reset, then 16'hE79E LSB first, then another line reset.
- R10: While idle the serial clock is high and the host drives the line low. Each clock half-period lasts `HALF_DIV` system clocks, and driven line values change only while the serial clock is low.
- R11: A command is accepted only when `busy` is 0. `cmd_valid` during an operation is ignored, and each accepted command yields exactly one single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a command (taken when idle) |
| cmd_op | input | 2 | 00 transfer, 01 line reset, 1x switch sequence |
| cmd_ap | input | 1 | 1 selects an access-port register, 0 a debug-port register |
| cmd_rnw | input | 1 | 1 read, 0 write |
| cmd_addr | input | 2 | Register address bits [3:2] |
| cmd_wdata | input | 32 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ack | output | 3 | Last acknowledge received |
| rdata | output | 32 | Last successfully read word |
| parity_error | output | 1 | Read parity mismatch on last transfer |
| swclk | output | 1 | Serial clock |
| swdio_out | output | 1 | Data value driven by the host |
| swdio_oe | output | 1 | Host drives the data line when 1 |
| swdio_in | input | 1 | Data line as seen by the host |

## Verification
The bench builds the engine with `HALF_DIV`=2 and `RESET_CYCLES`=50. Two system clocks per half-bit is the narrowest spacing at which the bench's target model can still change its bit clearly after the falling edge. It also keeps a 46-bit transfer near 184 cycles, so every acknowledge kind, both parity outcomes, both reset sequences and a command issued while busy all fit in one short run. Keeping the reset length at its minimum of 50 means the exact bit count of both sequences is checked at the value the link requires.

// File: rtl/swd_host.sv
module swd_host #(
  parameter int HALF_DIV     = 4,
  parameter int RESET_CYCLES = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic        cmd_ap,
  input  logic        cmd_rnw,
  input  logic [1:0]  cmd_addr,
  input  logic [31:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [2:0]  ack,
  output logic [31:0] rdata,
  output logic        parity_error,
  output logic        swclk,
  output logic        swdio_out,
  output logic        swdio_oe,
  input  logic        swdio_in
);
  localparam int DW   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int MAXB = (RESET_CYCLES > 33) ? RESET_CYCLES : 33;
  localparam int CW   = $clog2(MAXB + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RST1, S_JSEQ, S_RST2, S_REQ, S_TRNA, S_ACK, S_TRNW, S_WDAT, S_RDAT, S_TRNE
  } st_t;

  st_t            st;
  logic [DW-1:0]  dcnt;
  logic           ph;
  logic [CW-1:0]  cnt;
  logic [32:0]    sh, rx;
  logic           sw_q, rnw_q;
  logic [31:0]    wdata_q;

  wire half_end = (dcnt == DW'(HALF_DIV - 1));
  wire rise     = (st != S_IDLE) && !ph && half_end;
  wire slot_end = (st != S_IDLE) && ph && half_end;
  wire last     = (cnt == CW'(1));
  wire req_par  = cmd_ap ^ cmd_rnw ^ cmd_addr[0] ^ cmd_addr[1];
  wire in_rst   = (st == S_RST1) || (st == S_RST2);

  assign busy      = (st != S_IDLE);
  assign swclk     = (st == S_IDLE) | ph;
  assign swdio_oe  = (st == S_IDLE) || in_rst || (st == S_JSEQ) || (st == S_REQ) || (st == S_WDAT);
  assign swdio_out = in_rst | (((st == S_JSEQ) || (st == S_REQ) || (st == S_WDAT)) & sh[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dcnt <= '0; ph <= 1'b0; cnt <= '0;
      sh <= '0; rx <= '0; sw_q <= 1'b0; rnw_q <= 1'b0; wdata_q <= '0;
      done <= 1'b0; ack <= '0; rdata <= '0; parity_error <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        dcnt <= '0;
        ph   <= 1'b0;
        if (cmd_valid) begin
          if (cmd_op == 2'b00) begin
            st      <= S_REQ;
            cnt     <= CW'(8);
            sh      <= {25'd0, 1'b1, 1'b0, req_par, cmd_addr[1], cmd_addr[0], cmd_rnw, cmd_ap, 1'b1};
            rnw_q   <= cmd_rnw;
            wdata_q <= cmd_wdata;
          end else begin
            st   <= S_RST1;
            cnt  <= CW'(RESET_CYCLES);
            sw_q <= cmd_op[1];
          end
        end
      end else begin
        if (half_end) begin
          dcnt <= '0;
          ph   <= ~ph;
        end else begin
          dcnt <= dcnt + DW'(1);
        end
        if (rise) rx <= {swdio_in, rx[32:1]};
        if (slot_end) begin
          sh  <= sh >> 1;
          cnt <= cnt - CW'(1);
          if (last) begin
            case (st)
              S_RST1: if (sw_q) begin
                        st <= S_JSEQ; cnt <= CW'(16); sh <= {17'd0, 16'hE79E};
                      end else begin
                        st <= S_IDLE; done <= 1'b1;
                      end
              S_JSEQ: begin st <= S_RST2; cnt <= CW'(RESET_CYCLES); end
              S_REQ:  begin st <= S_TRNA; cnt <= CW'(1); end
              S_TRNA: begin st <= S_ACK;  cnt <= CW'(3); end
              S_ACK: begin
                ack          <= rx[32:30];
                parity_error <= 1'b0;
                if (rx[32:30] == 3'b001) begin
                  st  <= rnw_q ? S_RDAT : S_TRNW;
                  cnt <= rnw_q ? CW'(33) : CW'(1);
                end else begin
                  st  <= S_TRNE;
                  cnt <= CW'(1);
                end
              end
              S_TRNW: begin st <= S_WDAT; cnt <= CW'(33); sh <= {^wdata_q, wdata_q}; end
              S_RDAT: begin
                rdata        <= rx[31:0];
                parity_error <= ^rx;
                st           <= S_TRNE;
                cnt          <= CW'(1);
              end
              default: begin st <= S_IDLE; done <= 1'b1; end
            endcase
          end
        end
      end
    end
  end

  a_r10_oe_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(swdio_oe) |-> (!swclk || !busy));
  a_r10_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(swdio_out) && swdio_oe) |-> (!swclk || !busy));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);
  a_r5_perr_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    parity_error |-> (ack == 3'b001));
endmodule

// File: tb/tb_swd_host.sv
module tb_swd_host;
  localparam int HD = 2;
  localparam int RC = 50;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid = 1'b0, cmd_ap = 1'b0, cmd_rnw = 1'b0, swdio_in = 1'b1;
  logic [1:0] cmd_op = 2'b00, cmd_addr = 2'b00;
  logic [31:0] cmd_wdata = '0;
  logic busy, done, parity_error, swclk, swdio_out, swdio_oe;
  logic [2:0] ack;
  logic [31:0] rdata;

  always #10 clk = ~clk;

  swd_host #(.HALF_DIV(HD), .RESET_CYCLES(RC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ap(cmd_ap),
    .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .ack(ack), .rdata(rdata), .parity_error(parity_error), .swclk(swclk),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in));

  int n_chk = 0, n_fail = 0, k = 0, n_done = 0;
  logic resp [0:127];
  logic cap_oe [0:127];
  logic cap_out [0:127];
  logic [36:0] expq [$];
  logic [31:0] last_rd = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // target model: new bit shortly after each falling edge, sample host shortly after rising edge
  always @(negedge swclk) begin
    #1;
    if (k < 128) swdio_in = resp[k];
    k++;
  end
  always @(posedge swclk) begin
    #1;
    if (k > 0 && k <= 128) begin
      cap_oe[k-1]  = swdio_oe;
      cap_out[k-1] = swdio_out;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done) begin
      logic [36:0] e;
      n_done++;
      if (expq.size() == 0) chk(1'b0, "R11 done without command", 1, 0);
      else begin
        e = expq.pop_front();
        if (e[36]) begin
          chk(ack == e[35:33], "R3 acknowledge", ack, e[35:33]);
          chk(rdata == e[32:1], "R4 rdata", rdata, e[32:1]);
          chk(parity_error == e[0], "R5 parity_error", parity_error, e[0]);
        end
      end
    end
  end

  task automatic fill_resp();
    for (int i = 0; i < 128; i++) resp[i] = 1'b1;
  endtask

  task automatic start(input logic [1:0] op, input logic ap, input logic rnw,
                       input logic [1:0] addr, input logic [31:0] wd);
    while (busy) @(negedge clk);
    k = 0;
    cmd_op = op; cmd_ap = ap; cmd_rnw = rnw; cmd_addr = addr; cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input logic ap, input logic rnw, input logic [1:0] addr, input logic [31:0] wd,
                      input logic [2:0] ackv, input logic [31:0] rd, input bit flip, input bit poke);
    bit ok;
    int n0, slots;
    logic [7:0] expb, gotb;
    logic [32:0] g;
    bit oe_ok;
    logic pe;
    ok = (ackv == 3'b001);
    fill_resp();
    for (int i = 0; i < 3; i++) resp[9+i] = ackv[i];
    if (rnw && ok) begin
      for (int i = 0; i < 32; i++) resp[12+i] = rd[i];
      resp[44] = (^rd) ^ flip;
      last_rd = rd;
    end
    pe = rnw && ok && flip;
    expq.push_back({1'b1, ackv, last_rd, pe});
    n0 = n_done;
    start(2'b00, ap, rnw, addr, wd);
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_op = 2'b01; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
    end
    wait_idle();
    chk(n_done == n0 + 1, "R11 one done per command", n_done - n0, 1);
    slots = ok ? 46 : 13;
    chk(k == slots, ok ? (rnw ? "R4 read length" : "R6 write length") : "R7 short length", k, slots);
    expb = {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
    oe_ok = 1;
    for (int i = 0; i < 8; i++) begin gotb[i] = cap_out[i]; if (cap_oe[i] !== 1'b1) oe_ok = 0; end
    chk(oe_ok && gotb === expb, "R1 request bits", gotb, expb);
    oe_ok = 1;
    for (int i = 8; i < 12; i++) if (cap_oe[i] !== 1'b0) oe_ok = 0;
    chk(oe_ok, "R2 released for turnaround and ack", 0, 1);
    if (ok && !rnw) begin
      oe_ok = (cap_oe[12] === 1'b0);
      for (int i = 0; i < 33; i++) begin g[i] = cap_out[13+i]; if (cap_oe[13+i] !== 1'b1) oe_ok = 0; end
      chk(oe_ok && g === {^wd, wd}, "R6 write data and parity", g, {^wd, wd});
    end else if (ok) begin
      oe_ok = 1;
      for (int i = 12; i < 46; i++) if (cap_oe[i] !== 1'b0) oe_ok = 0;
      chk(oe_ok, "R4 released through data and turnaround", 0, 1);
    end else begin
      chk(cap_oe[12] === 1'b0, "R7 one released bit", cap_oe[12], 0);
    end
    chk(swdio_oe === 1'b1 && swdio_out === 1'b0 && swclk === 1'b1, "R10 idle drive after transfer",
        {swclk, swdio_oe, swdio_out}, 3'b110);
  endtask

  task automatic lreset(input bit sw);
    int slots;
    time t0;
    bit all1;
    logic [15:0] pat;
    fill_resp();
    expq.push_back('0);
    start(sw ? 2'b10 : 2'b01, 1'b0, 1'b0, 2'b00, '0);
    @(negedge swclk); t0 = $time;
    @(posedge swclk);
    chk(($time - t0) == HD * 20, "R10 half period", $time - t0, HD * 20);
    wait_idle();
    slots = sw ? 2 * RC + 16 : RC;
    chk(k == slots, sw ? "R9 sequence length" : "R8 reset length", k, slots);
    all1 = 1;
    for (int i = 0; i < slots; i++) begin
      if (cap_oe[i] !== 1'b1) all1 = 0;
      if ((!sw || i < RC || i >= RC + 16) && cap_out[i] !== 1'b1) all1 = 0;
    end
    chk(all1, "R8 line held high", 0, 1);
    if (sw) begin
      for (int i = 0; i < 16; i++) pat[i] = cap_out[RC+i];
      chk(pat === 16'hE79E, "R9 select pattern", pat, 16'hE79E);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fill_resp();
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && ack == 0 && rdata == 0 && parity_error == 0,
        "R11 reset outputs", {busy, done, ack, parity_error}, 0);
    chk(swclk === 1'b1 && swdio_oe === 1'b1 && swdio_out === 1'b0, "R10 reset idle line",
        {swclk, swdio_oe, swdio_out}, 3'b110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    lreset(0);
    lreset(1);
    xfer(1'b0, 1'b1, 2'b00, '0, 3'b001, 32'hDEADBEEF, 0, 0);
    xfer(1'b1, 1'b0, 2'b01, 32'h12345678, 3'b001, '0, 0, 0);
    xfer(1'b1, 1'b1, 2'b11, '0, 3'b001, 32'h80000001, 1, 0);
    xfer(1'b0, 1'b1, 2'b10, '0, 3'b001, 32'h00000000, 0, 0);
    xfer(1'b1, 1'b0, 2'b10, 32'hCAFEF00D, 3'b010, '0, 0, 0);
    xfer(1'b0, 1'b1, 2'b01, '0, 3'b100, 32'h55555555, 0, 0);
    xfer(1'b1, 1'b1, 2'b00, '0, 3'b111, 32'hAAAAAAAA, 0, 0);
    xfer(1'b0, 1'b0, 2'b11, 32'h0F0F0F0E, 3'b001, '0, 0, 1);
    xfer(1'b1, 1'b1, 2'b01, '0, 3'b001, 32'hFFFFFFFF, 0, 0);
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R11 all commands completed", expq.size(), 0);
    summary();
    $finish;
  end
endmodule